// File: doc/BRIEF.md
# Subarray Row Engine with In-Array Copy and Majority

A cycle-level, synthesizable model of one memory subarray: a bank of storage rows sits behind a single row of sense amplifiers. A controller opens a row, reads or writes byte-wide columns of it through the amplifier row, and closes the row before opening another. When a row is opened its full contents land in the amplifiers, and every change made there is also written back into the row's cells. Reading therefore never destroys the stored data.

Two operations work inside the array without moving data over the port. The first is a row copy. The controller opens a second row while a first row is still latched, and the latched contents overwrite the whole second row. The second is a triple activation of three reserved rows. It leaves every bit equal to the bitwise majority of the three rows, both in those rows and in the amplifiers. AND and OR of two operands follow from this when the third reserved row holds all zeros or all ones.

After each accepted open, close or triple activation, a ready output stays low for a fixed, configurable number of cycles. Any command that is illegal in the current state raises a one-cycle error and has no effect. This includes any command issued while ready is low.

Top module: `dram_subarray_rowops`

## Requirements
- R1: After reset, ready is 1, row_open, err and rd_valid are 0, and every stored row holds all zeros.
- R2: The cmd_op encoding is 0 idle, 1 open (activate), 2 read, 3 write, 4 close (precharge) and 5 triple activation. After a read accepted while a row is open, rd_valid is 1 for one cycle on the next clock, and rd_byte equals bits [8*c+7:8*c] of the open row, where c is col_sel.
- R3: A write accepted while a row is open stores wr_byte into bits [8*c+7:8*c] of both the amplifier row and that row's cells, so the data survives a close and a later reopen.
- R4: After an accepted open, close or triple activation, ready is 0 for exactly GAP_CYCLES cycles and then returns to 1.
- R5: An open command for the same subarray, issued while a row is already open, copies the entire latched row into the addressed row. The addressed row then becomes the open row, and the amplifier contents do not change.
- R6: An open command whose sub_sel differs from SUB_ID is flagged with err on the next cycle and ignored. No row is copied, and the open or closed state and the open row stay the same.
- R7: A triple activation issued while no row is open, with row_sel equal to the base reserved row ROWS-3, writes the bitwise majority (a&b)|(b&c)|(a&c) of rows ROWS-3, ROWS-2 and ROWS-1 into all three rows and into the amplifiers. It also leaves row ROWS-3 open.
- R8: A triple activation is flagged with err and ignored when a row is open, when row_sel is not ROWS-3, or when sub_sel differs from SUB_ID.
- R9: A read, write or close with no open row, or any command other than idle issued while ready is 0, is flagged with err on the next cycle and ignored. An ignored read gives no rd_valid.
- R10: The cmd_op values 6 and 7 are undefined. They are flagged with err and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code |
| sub_sel | input | SUB_W | Subarray field of the row address |
| row_sel | input | ROW_W | Row index within the subarray |
| col_sel | input | COL_W | Byte column within the row |
| wr_byte | input | 8 | Write data |
| rd_byte | output | 8 | Read data, held until the next read |
| rd_valid | output | 1 | One-cycle pulse marking new read data |
| ready | output | 1 | High when a command can be accepted |
| err | output | 1 | One-cycle pulse for a rejected command |
| row_open | output | 1 | A row is latched in the amplifiers |

## Verification
The design samples each command on a rising edge. Its effects appear after that same edge: err, rd_valid and rd_byte are valid one cycle after the command, and ready falls one cycle after an accepted open or close. The bench drives inputs on falling edges and holds each command for exactly one cycle. It reads the outputs on the next falling edge, which is the first point where the registered results are due. It measures the ready gap by counting falling edges until ready returns. Effects inside the array are confirmed through later opens and reads, never by looking at the cells directly.

// File: rtl/dram_subarray_rowops.sv
module dram_subarray_rowops #(
  parameter int ROW_BITS   = 64,
  parameter int ROWS       = 16,
  parameter int SUB_W      = 2,
  parameter int SUB_ID     = 1,
  parameter int GAP_CYCLES = 3,
  localparam int COLS      = ROW_BITS / 8,
  localparam int COL_W     = $clog2(COLS),
  localparam int ROW_W     = $clog2(ROWS),
  localparam int BUSY_W    = $clog2(GAP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_op,
  input  logic [SUB_W-1:0] sub_sel,
  input  logic [ROW_W-1:0] row_sel,
  input  logic [COL_W-1:0] col_sel,
  input  logic [7:0]       wr_byte,
  output logic [7:0]       rd_byte,
  output logic             rd_valid,
  output logic             ready,
  output logic             err,
  output logic             row_open
);

  localparam logic [2:0] OP_IDLE = 3'd0;
  localparam logic [2:0] OP_OPEN = 3'd1;
  localparam logic [2:0] OP_RD   = 3'd2;
  localparam logic [2:0] OP_WR   = 3'd3;
  localparam logic [2:0] OP_CLS  = 3'd4;
  localparam logic [2:0] OP_TRI  = 3'd5;
  localparam int TRI_BASE = ROWS - 3;

  logic [ROW_BITS-1:0] cells [ROWS];
  logic [ROW_BITS-1:0] amp;
  logic [ROW_W-1:0]    open_row;
  logic [BUSY_W-1:0]   busy;

  logic                here, row_ok, legal, accept, bad;
  logic [ROW_BITS-1:0] maj;
  logic [COL_W+2:0]    bit_base;

  assign ready    = (busy == '0);
  assign here     = (int'(sub_sel) == SUB_ID);
  assign row_ok   = (int'(row_sel) < ROWS);
  assign bit_base = {col_sel, 3'b000};

  assign maj = (cells[TRI_BASE] & cells[TRI_BASE+1]) |
               (cells[TRI_BASE+1] & cells[TRI_BASE+2]) |
               (cells[TRI_BASE] & cells[TRI_BASE+2]);

  always_comb begin
    case (cmd_op)
      OP_OPEN: legal = here && row_ok;
      OP_RD,
      OP_WR,
      OP_CLS:  legal = row_open;
      OP_TRI:  legal = !row_open && here && (int'(row_sel) == TRI_BASE);
      default: legal = 1'b0;
    endcase
  end

  assign accept = ready && legal;
  assign bad    = (cmd_op != OP_IDLE) && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) cells[i] <= '0;
      amp      <= '0;
      open_row <= '0;
      row_open <= 1'b0;
      busy     <= '0;
      rd_byte  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      err      <= bad;
      rd_valid <= 1'b0;
      if (busy != '0) busy <= busy - 1'b1;
      if (accept) begin
        case (cmd_op)
          OP_OPEN: begin
            if (row_open) cells[row_sel] <= amp;
            else          amp <= cells[row_sel];
            row_open <= 1'b1;
            open_row <= row_sel;
            busy     <= BUSY_W'(GAP_CYCLES);
          end
          OP_RD: begin
            rd_byte  <= amp[bit_base +: 8];
            rd_valid <= 1'b1;
          end
          OP_WR: begin
            amp[bit_base +: 8]             <= wr_byte;
            cells[open_row][bit_base +: 8] <= wr_byte;
          end
          OP_CLS: begin
            row_open <= 1'b0;
            busy     <= BUSY_W'(GAP_CYCLES);
          end
          OP_TRI: begin
            cells[TRI_BASE]   <= maj;
            cells[TRI_BASE+1] <= maj;
            cells[TRI_BASE+2] <= maj;
            amp      <= maj;
            row_open <= 1'b1;
            open_row <= ROW_W'(TRI_BASE);
            busy     <= BUSY_W'(GAP_CYCLES);
          end
          default: ;
        endcase
      end
    end
  end

  assert_gap_after_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_op == OP_OPEN && here && row_ok) |=> !ready);

  assert_gap_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_op == OP_CLS && row_open) |=> (!ready && !row_open));

  assert_read_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_RD && !row_open) |=> (err && !rd_valid));

  assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && cmd_op != OP_IDLE) |=> err);

  assert_read_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_op == OP_RD && row_open));

  assert_foreign_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_OPEN && !here) |=> (err && $stable(row_open) && $stable(open_row)));

  assert_tri_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_op == OP_TRI && !row_open && here && int'(row_sel) == TRI_BASE)
      |=> (row_open && !ready && int'(open_row) == TRI_BASE));

  assert_tri_misaddr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_TRI && int'(row_sel) != TRI_BASE) |=> (err && $stable(row_open)));

  assert_undef_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd6 || cmd_op == 3'd7) |=> err);

  assert_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_valid);

endmodule

// File: tb/tb_dram_subarray_rowops.sv
`timescale 1ns/1ps
module tb_dram_subarray_rowops;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] sub_sel = 2'd0;
  logic [3:0] row_sel = 4'd0;
  logic [2:0] col_sel = 3'd0;
  logic [7:0] wr_byte = 8'd0;
  logic [7:0] rd_byte;
  logic       rd_valid, ready, err, row_open;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dram_subarray_rowops #(
    .ROW_BITS(64), .ROWS(16), .SUB_W(2), .SUB_ID(1), .GAP_CYCLES(3)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .sub_sel(sub_sel),
    .row_sel(row_sel), .col_sel(col_sel), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .ready(ready),
    .err(err), .row_open(row_open)
  );

  // fields: req[33:30] op[29:27] sub[26:25] row[24:21] col[20:18] wd[17:10] chk[9] exp[8:1] eerr[0]
  localparam int NV = 51;
  localparam logic [33:0] VEC [NV] = '{
    {4'd2, 3'd1,2'd1,4'd2, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R2 open row 2
    {4'd3, 3'd3,2'd1,4'd0, 3'd0,8'hA1,1'b0,8'h00,1'b0},   // R3 write col 0
    {4'd3, 3'd3,2'd1,4'd0, 3'd7,8'h5C,1'b0,8'h00,1'b0},   // R3 write col 7
    {4'd2, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b1,8'hA1,1'b0},   // R2 read col 0
    {4'd2, 3'd2,2'd1,4'd0, 3'd7,8'h00,1'b1,8'h5C,1'b0},   // R2 read col 7
    {4'd2, 3'd2,2'd1,4'd0, 3'd3,8'h00,1'b1,8'h00,1'b0},   // R2 read untouched col
    {4'd3, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R3 close
    {4'd3, 3'd1,2'd1,4'd2, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R3 reopen
    {4'd3, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b1,8'hA1,1'b0},   // R3 data persisted
    {4'd5, 3'd1,2'd1,4'd5, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R5 copy 2 -> 5
    {4'd5, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R5 close
    {4'd5, 3'd1,2'd1,4'd5, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R5 open row 5
    {4'd5, 3'd2,2'd1,4'd0, 3'd7,8'h00,1'b1,8'h5C,1'b0},   // R5 copied col 7
    {4'd5, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b1,8'hA1,1'b0},   // R5 copied col 0
    {4'd5, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R5 close
    {4'd6, 3'd1,2'd1,4'd2, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R6 open row 2
    {4'd6, 3'd1,2'd0,4'd6, 3'd0,8'h00,1'b0,8'h00,1'b1},   // R6 foreign copy rejected
    {4'd6, 3'd2,2'd1,4'd0, 3'd7,8'h00,1'b1,8'h5C,1'b0},   // R6 row 2 still open
    {4'd6, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R6 close
    {4'd6, 3'd1,2'd1,4'd6, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R6 open row 6
    {4'd6, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b1,8'h00,1'b0},   // R6 row 6 not copied
    {4'd6, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},   // R6 close
    {4'd9, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b1},   // R9 read closed
    {4'd9, 3'd3,2'd1,4'd0, 3'd0,8'hFF,1'b0,8'h00,1'b1},   // R9 write closed
    {4'd9, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b1},   // R9 close closed
    {4'd10,3'd7,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b1},   // R10 op 7
    {4'd10,3'd6,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b1},   // R10 op 6
    {4'd7, 3'd1,2'd1,4'd13,3'd0,8'h00,1'b0,8'h00,1'b0},   // R7 load row 13
    {4'd7, 3'd3,2'd1,4'd0, 3'd0,8'hF0,1'b0,8'h00,1'b0},
    {4'd7, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},
    {4'd7, 3'd1,2'd1,4'd14,3'd0,8'h00,1'b0,8'h00,1'b0},   // R7 load row 14
    {4'd7, 3'd3,2'd1,4'd0, 3'd0,8'hCC,1'b0,8'h00,1'b0},
    {4'd7, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},
    {4'd7, 3'd1,2'd1,4'd15,3'd0,8'h00,1'b0,8'h00,1'b0},   // R7 load row 15
    {4'd7, 3'd3,2'd1,4'd0, 3'd0,8'hAA,1'b0,8'h00,1'b0},
    {4'd7, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b1,8'hAA,1'b0},
    {4'd8, 3'd5,2'd1,4'd13,3'd0,8'h00,1'b0,8'h00,1'b1},   // R8 triple while open
    {4'd8, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},
    {4'd8, 3'd5,2'd1,4'd12,3'd0,8'h00,1'b0,8'h00,1'b1},   // R8 triple wrong row
    {4'd8, 3'd5,2'd0,4'd13,3'd0,8'h00,1'b0,8'h00,1'b1},   // R8 triple foreign sub
    {4'd7, 3'd5,2'd1,4'd13,3'd0,8'h00,1'b0,8'h00,1'b0},   // R7 triple activation
    {4'd7, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b1,8'hE8,1'b0},   // R7 majority in amps
    {4'd7, 3'd2,2'd1,4'd0, 3'd1,8'h00,1'b1,8'h00,1'b0},   // R7 zero columns
    {4'd7, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},
    {4'd7, 3'd1,2'd1,4'd14,3'd0,8'h00,1'b0,8'h00,1'b0},
    {4'd7, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b1,8'hE8,1'b0},   // R7 row 14 holds majority
    {4'd7, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},
    {4'd7, 3'd1,2'd1,4'd15,3'd0,8'h00,1'b0,8'h00,1'b0},
    {4'd7, 3'd2,2'd1,4'd0, 3'd0,8'h00,1'b1,8'hE8,1'b0},   // R7 row 15 holds majority
    {4'd7, 3'd4,2'd1,4'd0, 3'd0,8'h00,1'b0,8'h00,1'b0},
    {4'd6, 3'd1,2'd2,4'd2, 3'd0,8'h00,1'b0,8'h00,1'b1}    // R6 foreign open while closed
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] s, input logic [3:0] r,
                       input logic [2:0] c, input logic [7:0] wd, input bit wait_rdy);
    if (wait_rdy) while (!ready) @(negedge clk);
    cmd_op = op; sub_sel = s; row_sel = r; col_sel = c; wr_byte = wd;
    @(negedge clk);
    cmd_op = 3'd0;
  endtask

  initial begin
    #(8.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ready", ready, 1);
    check("R1", "row_open", row_open, 0);
    check("R1", "err", err, 0);
    check("R1", "rd_valid", rd_valid, 0);
    issue(3'd1, 2'd1, 4'd9, 3'd0, 8'h00, 1'b1);
    issue(3'd2, 2'd1, 4'd0, 3'd4, 8'h00, 1'b1);
    check("R1", "row 9 zero", rd_byte, 0);
    issue(3'd4, 2'd1, 4'd0, 3'd0, 8'h00, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[33:30]);
      issue(v[29:27], v[26:25], v[24:21], v[20:18], v[17:10], 1'b1);
      check(tag, $sformatf("err vec %0d", i), err, v[0]);
      if (v[9]) begin
        check(tag, $sformatf("rd_valid vec %0d", i), rd_valid, 1);
        check(tag, $sformatf("rd_byte vec %0d", i), rd_byte, v[8:1]);
      end
    end

    // R4 ready gap after open and close
    issue(3'd1, 2'd1, 4'd2, 3'd0, 8'h00, 1'b1);
    gap = 0;
    while (!ready && gap < 100) begin gap++; @(negedge clk); end
    check("R4", "gap after open", gap, 3);
    issue(3'd4, 2'd1, 4'd0, 3'd0, 8'h00, 1'b1);
    gap = 0;
    while (!ready && gap < 100) begin gap++; @(negedge clk); end
    check("R4", "gap after close", gap, 3);

    // R4 gap after triple activation
    issue(3'd5, 2'd1, 4'd13, 3'd0, 8'h00, 1'b1);
    gap = 0;
    while (!ready && gap < 100) begin gap++; @(negedge clk); end
    check("R4", "gap after triple", gap, 3);
    check("R7", "triple leaves row open", row_open, 1);
    issue(3'd2, 2'd1, 4'd0, 3'd0, 8'h00, 1'b1);
    check("R7", "majority stable", rd_byte, 8'hE8);
    issue(3'd4, 2'd1, 4'd0, 3'd0, 8'h00, 1'b1);

    // R9 commands while busy are rejected and ignored
    issue(3'd1, 2'd1, 4'd2, 3'd0, 8'h00, 1'b1);
    issue(3'd4, 2'd1, 4'd0, 3'd0, 8'h00, 1'b0);
    check("R9", "close while busy err", err, 1);
    issue(3'd2, 2'd1, 4'd0, 3'd0, 8'h00, 1'b0);
    check("R9", "read while busy err", err, 1);
    check("R9", "read while busy no valid", rd_valid, 0);
    while (!ready) @(negedge clk);
    check("R9", "row still open", row_open, 1);
    issue(3'd2, 2'd1, 4'd0, 3'd7, 8'h00, 1'b1);
    check("R9", "open row intact", rd_byte, 8'h5C);
    check("R9", "no err on legal read", err, 0);
    issue(3'd4, 2'd1, 4'd0, 3'd0, 8'h00, 1'b1);
    check("R9", "closed", row_open, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule